// File: doc/BRIEF.md
# Video Capture Write-Address Generator

This block turns an incoming captured video word stream into frame-memory byte addresses. A frame sync sets the current line start to one of two base addresses, which lets software double-buffer captured frames. Each line sync moves the line start forward by a programmable stride. Inside a line, every accepted 32-bit word takes the current address, and the address then steps by four bytes. All address arithmetic wraps at 2^AW bytes, with AW = 22 by default.

The block runs its own sync edge detection on the two raw sync inputs, and the polarity of each is selectable. Software can inject frame or line syncs by pulsing a strobe. It can also force the address to reload from the selected base. One option skips every other frame. Another suppresses the stride step on the first line sync of a frame. Sticky end-of-frame and end-of-line flags, each with its own enable, drive one interrupt line.

Words arrive on a valid/ready input and leave on a valid/ready output that carries the write address. While a frame is being kept, the input passes straight through: `wr_valid` follows `pix_valid` and `pix_ready` follows `wr_ready`, so back-pressure from memory holds the address. While a frame is being dropped, or before the first frame sync after reset, words are accepted and discarded and nothing is issued.

Top module: `capaddr_top`

## Requirements
- R1: Out of reset the block issues no writes (`wr_valid` 0, `pix_ready` 1), both status flags are 0 and `irq` is 0, until the first frame sync event.
- R2: A frame sync event loads the address and the line start from `base1` when `buf_sel` is 1 and from `base0` when it is 0, with the low three bits of the base forced to 0.
- R3: Each accepted word (`pix_valid`, `wr_ready` and a kept frame) that meets no sync or reload event in the same cycle advances `wr_addr` by 4, modulo 2^AW.
- R4: In a kept frame `wr_valid` equals `pix_valid` and `pix_ready` equals `wr_ready`. While `wr_valid` is high and `wr_ready` is low, the address holds.
- R5: A line sync event moves the line start forward by `stride` with its low two bits forced to 0, and sets the address to the new line start.
- R6: With `no_first_stride` set, the first line sync after a frame sync keeps the line start unchanged and only returns the address to it. Later line syncs in that frame add the stride.
- R7: With `skip_alt_frames` set, frames are counted from the first frame sync after reset, starting at 0, and odd-numbered frames are dropped (`wr_valid` 0, `pix_ready` 1). With the bit clear, every frame is kept.
- R8: A raw sync input is active high when its polarity bit is 1 and active low when it is 0. The change to the active level is registered at one clock edge, and the event takes effect at the next edge.
- R9: A 1 on `sw_fsync` or `sw_lsync` acts as a frame or line sync event at the next clock edge.
- R10: A 1 on `sw_load_base` reloads the address and the line start from the selected, aligned base at the next edge. The priority order is frame event, then reload, then line event, then word step.
- R11: `eof_status` and `eol_status` are set by frame and line events and stay set until a 1 on `eof_clr` or `eol_clr` clears them. A set in the same cycle wins over a clear.
- R12: `irq` is high exactly when an enabled status flag is set (`eof_status & eof_irq_en` or `eol_status & eol_irq_en`).
- R13: The address wraps from 2^AW-4 to 0 when a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_raw | input | 1 | Raw frame sync |
| lsync_raw | input | 1 | Raw line sync |
| fsync_pol | input | 1 | Frame sync polarity, 1 = active high |
| lsync_pol | input | 1 | Line sync polarity, 1 = active high |
| sw_fsync | input | 1 | Software frame sync strobe |
| sw_lsync | input | 1 | Software line sync strobe |
| sw_load_base | input | 1 | Software base reload strobe |
| base0 | input | AW | Buffer 0 base (low 3 bits ignored) |
| base1 | input | AW | Buffer 1 base (low 3 bits ignored) |
| buf_sel | input | 1 | Selects base1 when 1 |
| stride | input | AW | Line stride in bytes (low 2 bits ignored) |
| no_first_stride | input | 1 | Skip stride on first line sync of a frame |
| skip_alt_frames | input | 1 | Drop every other frame |
| pix_valid | input | 1 | Input word valid |
| pix_ready | output | 1 | Input word accepted |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | AW | Write byte address |
| eof_irq_en | input | 1 | End-of-frame interrupt enable |
| eol_irq_en | input | 1 | End-of-line interrupt enable |
| eof_clr | input | 1 | Write-1 clear of end-of-frame flag |
| eol_clr | input | 1 | Write-1 clear of end-of-line flag |
| eof_status | output | 1 | Sticky end-of-frame flag |
| eol_status | output | 1 | Sticky end-of-line flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are collisions: a frame or reload event that lands in the same cycle as a line event or an accepted word, a polarity flip that itself forms an edge, and a clear that arrives together with a new event. The bench reaches them with long random runs in which syncs, strobes, stalls and configuration bits all change at low, independent rates. It also places directed cases at the exact collision cycles and at the top of the address space, where the wrap occurs.

// File: rtl/capaddr_pkg.sv
package capaddr_pkg;
  typedef struct packed {
    logic frame;
    logic load;
    logic line;
  } seq_evt_t;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BASE_ALIGN = 3;
  localparam int unsigned STRIDE_ALIGN = 2;
endpackage

// File: rtl/capaddr_sync_edge.sv
module capaddr_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic active_high,
  output logic pulse
);
  logic lvl_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= active_high ? raw : ~raw;
      prev_q <= lvl_q;
    end
  end

  assign pulse = lvl_q & ~prev_q;
endmodule

// File: rtl/capaddr_seq.sv
module capaddr_seq
  import capaddr_pkg::*;
#(
  parameter int unsigned AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_evt_t      evt,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic          buf_sel,
  input  logic [AW-1:0] stride,
  input  logic          no_first_stride,
  input  logic          skip_alt_frames,
  input  logic          word_fire,
  output logic [AW-1:0] addr,
  output logic          keep
);
  localparam logic [AW-1:0] BASE_MASK   = ~((AW'(1) << BASE_ALIGN) - AW'(1));
  localparam logic [AW-1:0] STRIDE_MASK = ~((AW'(1) << STRIDE_ALIGN) - AW'(1));
  localparam logic [AW-1:0] STEP        = AW'(WORD_BYTES);

  logic [AW-1:0] line_start_q;
  logic [AW-1:0] addr_q;
  logic          first_q;
  logic          odd_q;
  logic          keep_q;
  logic [AW-1:0] sel_base;
  logic [AW-1:0] next_line;

  assign sel_base  = (buf_sel ? base1 : base0) & BASE_MASK;
  assign next_line = (first_q && no_first_stride) ? line_start_q
                                                  : line_start_q + (stride & STRIDE_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_start_q <= '0;
      addr_q       <= '0;
      first_q      <= 1'b0;
      odd_q        <= 1'b0;
      keep_q       <= 1'b0;
    end else begin
      if (evt.frame) begin
        line_start_q <= sel_base;
        addr_q       <= sel_base;
        keep_q       <= ~skip_alt_frames | ~odd_q;
        odd_q        <= ~odd_q;
      end else if (evt.load) begin
        line_start_q <= sel_base;
        addr_q       <= sel_base;
      end else if (evt.line) begin
        line_start_q <= next_line;
        addr_q       <= next_line;
      end else if (word_fire) begin
        addr_q <= addr_q + STEP;
      end

      if (evt.frame)     first_q <= 1'b1;
      else if (evt.line) first_q <= 1'b0;
    end
  end

  assign addr = addr_q;
  assign keep = keep_q;
endmodule

// File: rtl/capaddr_status.sv
module capaddr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_evt,
  input  logic line_evt,
  input  logic eof_clr,
  input  logic eol_clr,
  input  logic eof_irq_en,
  input  logic eol_irq_en,
  output logic eof_status,
  output logic eol_status,
  output logic irq
);
  logic eof_q;
  logic eol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_q <= 1'b0;
      eol_q <= 1'b0;
    end else begin
      eof_q <= frame_evt | (eof_q & ~eof_clr);
      eol_q <= line_evt  | (eol_q & ~eol_clr);
    end
  end

  assign eof_status = eof_q;
  assign eol_status = eol_q;
  assign irq        = (eof_q & eof_irq_en) | (eol_q & eol_irq_en);
endmodule

// File: rtl/capaddr_top.sv
module capaddr_top
  import capaddr_pkg::*;
#(
  parameter int unsigned AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync_raw,
  input  logic          lsync_raw,
  input  logic          fsync_pol,
  input  logic          lsync_pol,
  input  logic          sw_fsync,
  input  logic          sw_lsync,
  input  logic          sw_load_base,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic          buf_sel,
  input  logic [AW-1:0] stride,
  input  logic          no_first_stride,
  input  logic          skip_alt_frames,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  input  logic          eof_irq_en,
  input  logic          eol_irq_en,
  input  logic          eof_clr,
  input  logic          eol_clr,
  output logic          eof_status,
  output logic          eol_status,
  output logic          irq
);
  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] raw_v;
  logic [NSYNC-1:0] pol_v;
  logic [NSYNC-1:0] hw_evt;
  seq_evt_t         evt;
  logic             keep;
  logic             word_fire;

  assign raw_v = {lsync_raw, fsync_raw};
  assign pol_v = {lsync_pol, fsync_pol};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    capaddr_sync_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (raw_v[g]),
      .active_high(pol_v[g]),
      .pulse      (hw_evt[g])
    );
  end

  assign evt.frame = hw_evt[0] | sw_fsync;
  assign evt.line  = hw_evt[1] | sw_lsync;
  assign evt.load  = sw_load_base;

  assign wr_valid  = pix_valid & keep;
  assign pix_ready = wr_ready | ~keep;
  assign word_fire = pix_valid & wr_ready & keep;

  capaddr_seq #(.AW(AW)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt            (evt),
    .base0          (base0),
    .base1          (base1),
    .buf_sel        (buf_sel),
    .stride         (stride),
    .no_first_stride(no_first_stride),
    .skip_alt_frames(skip_alt_frames),
    .word_fire      (word_fire),
    .addr           (wr_addr),
    .keep           (keep)
  );

  capaddr_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_evt (evt.frame),
    .line_evt  (evt.line),
    .eof_clr   (eof_clr),
    .eol_clr   (eol_clr),
    .eof_irq_en(eof_irq_en),
    .eol_irq_en(eol_irq_en),
    .eof_status(eof_status),
    .eol_status(eol_status),
    .irq       (irq)
  );
endmodule

// File: rtl/capaddr_chk.sv
module capaddr_chk #(
  parameter int unsigned AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_evt,
  input logic          line_evt,
  input logic          load_evt,
  input logic          word_fire,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] base0,
  input logic [AW-1:0] base1,
  input logic          buf_sel,
  input logic          eof_status,
  input logic          eol_status,
  input logic          eol_clr
);
  logic          any_evt;
  logic [AW-1:0] exp_base;

  assign any_evt  = frame_evt | line_evt | load_evt;
  assign exp_base = {(buf_sel ? base1[AW-1:3] : base0[AW-1:3]), 3'b000};

  a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && !any_evt) |=> (wr_addr == $past(wr_addr) + AW'(4)));

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !any_evt) |=> $stable(wr_addr));

  a_r2_frame_base: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> (wr_addr == $past(exp_base)));

  a_r11_eof_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> eof_status);

  a_r11_eol_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_clr && !line_evt) |=> !eol_status);

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));
endmodule

bind capaddr_top capaddr_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_evt (evt.frame),
  .line_evt  (evt.line),
  .load_evt  (evt.load),
  .word_fire (word_fire),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .base0     (base0),
  .base1     (base1),
  .buf_sel   (buf_sel),
  .eof_status(eof_status),
  .eol_status(eol_status),
  .eol_clr   (eol_clr)
);

// File: tb/capaddr_top_tb_top.sv
module capaddr_top_tb_top;
  localparam int AW = 22;
  localparam logic [AW-1:0] BMASK = ~22'h7;
  localparam logic [AW-1:0] SMASK = ~22'h3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic fsync_raw, lsync_raw, fsync_pol, lsync_pol;
  logic sw_fsync, sw_lsync, sw_load_base;
  logic [AW-1:0] base0, base1, stride;
  logic buf_sel, no_first_stride, skip_alt_frames;
  logic pix_valid, pix_ready, wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic eof_irq_en, eol_irq_en, eof_clr, eol_clr;
  logic eof_status, eol_status, irq;

  capaddr_top #(.AW(AW)) dut_i (.*);

  // bench reference state
  logic m_lf, m_pf, m_ll, m_pl;
  logic [AW-1:0] m_ls, m_addr;
  logic m_first, m_odd, m_keep, m_eof, m_eol;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [AW-1:0] pick_base(input logic sel, input logic [AW-1:0] b0,
                                              input logic [AW-1:0] b1);
    return (sel ? b1 : b0) & BMASK;
  endfunction

  function automatic logic [AW-1:0] line_next(input logic [AW-1:0] ls, input logic [AW-1:0] st,
                                              input logic suppress);
    return suppress ? ls : ls + (st & SMASK);
  endfunction

  task automatic clear_strobes();
    sw_fsync = 0; sw_lsync = 0; sw_load_base = 0; eof_clr = 0; eol_clr = 0;
  endtask

  task automatic model_reset();
    m_lf = 0; m_pf = 0; m_ll = 0; m_pl = 0; m_ls = '0; m_addr = '0;
    m_first = 0; m_odd = 0; m_keep = 0; m_eof = 0; m_eol = 0;
  endtask

  // compare outputs against the model, then advance the model and the clock
  task automatic step(input string tag);
    logic e_valid, e_ready, e_irq, fev, lev, fire;
    logic [AW-1:0] b, nl;
    #1;
    e_valid = pix_valid & m_keep;
    e_ready = wr_ready | ~m_keep;
    e_irq   = (m_eof & eof_irq_en) | (m_eol & eol_irq_en);
    vectors++;
    if (wr_valid !== e_valid || pix_ready !== e_ready || wr_addr !== m_addr ||
        eof_status !== m_eof || eol_status !== m_eol || irq !== e_irq) begin
      fails++;
      $display("FAIL %s: got v=%b r=%b a=%h eof=%b eol=%b irq=%b exp v=%b r=%b a=%h eof=%b eol=%b irq=%b",
               tag, wr_valid, pix_ready, wr_addr, eof_status, eol_status, irq,
               e_valid, e_ready, m_addr, m_eof, m_eol, e_irq);
    end
    fev  = (m_lf & ~m_pf) | sw_fsync;
    lev  = (m_ll & ~m_pl) | sw_lsync;
    fire = pix_valid & wr_ready & m_keep;
    b    = pick_base(buf_sel, base0, base1);
    nl   = line_next(m_ls, stride, m_first & no_first_stride);
    if (fev) begin
      m_ls = b; m_addr = b; m_keep = ~skip_alt_frames | ~m_odd; m_odd = ~m_odd;
    end else if (sw_load_base) begin
      m_ls = b; m_addr = b;
    end else if (lev) begin
      m_ls = nl; m_addr = nl;
    end else if (fire) begin
      m_addr = m_addr + AW'(4);
    end
    if (fev) m_first = 1'b1;
    else if (lev) m_first = 1'b0;
    m_eof = fev | (m_eof & ~eof_clr);
    m_eol = lev | (m_eol & ~eol_clr);
    m_pf = m_lf; m_lf = fsync_pol ? fsync_raw : ~fsync_raw;
    m_pl = m_ll; m_ll = lsync_pol ? lsync_raw : ~lsync_raw;
    @(posedge clk);
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic expect_addr(input string tag, input logic [AW-1:0] exp);
    #1;
    vectors++;
    if (wr_addr !== exp) begin
      fails++;
      $display("FAIL %s: wr_addr got %h exp %h", tag, wr_addr, exp);
    end
  endtask

  task automatic run_words(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1; step(tag);
    end
    pix_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    fsync_raw = 0; lsync_raw = 0; fsync_pol = 1; lsync_pol = 1;
    clear_strobes();
    base0 = 22'h010005; base1 = 22'h12345F; buf_sel = 0; stride = 22'h000283;
    no_first_stride = 0; skip_alt_frames = 0; pix_valid = 0; wr_ready = 1;
    eof_irq_en = 0; eol_irq_en = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: idle after reset
    pix_valid = 1; step("R1 reset idle"); step("R1 reset idle"); pix_valid = 0;

    // R8: hardware frame sync, active high, two-edge latency
    fsync_raw = 1; step("R8 raw edge"); fsync_raw = 0; step("R8 event");
    step("R8 applied");
    // R2: buffer 0 base aligned
    expect_addr("R2 base0", 22'h010000);
    run_words("R3 words", 5);
    expect_addr("R3 five words", 22'h010014);

    // R4: stall holds address
    wr_ready = 0; run_words("R4 stall", 4); wr_ready = 1;
    expect_addr("R4 held", 22'h010014);

    // R5: line sync adds aligned stride
    sw_lsync = 1; step("R5 line"); step("R5 applied");
    expect_addr("R5 stride", 22'h010280);

    // R2: buffer 1 via software frame sync (R9)
    buf_sel = 1; sw_fsync = 1; step("R9 sw frame"); step("R2 base1");
    expect_addr("R2 base1", 22'h123458);

    // R6: first line sync suppressed
    no_first_stride = 1; run_words("R6 words", 3);
    sw_lsync = 1; step("R6 first line"); step("R6 first line");
    expect_addr("R6 suppressed", 22'h123458);
    sw_lsync = 1; step("R6 second line"); step("R6 second line");
    expect_addr("R6 second adds", 22'h1236D8);
    no_first_stride = 0;

    // R10: reload and priority frame > load > line
    run_words("R10 words", 2);
    sw_load_base = 1; sw_lsync = 1; step("R10 load beats line"); step("R10 load");
    expect_addr("R10 reload", 22'h123458);
    buf_sel = 0; sw_fsync = 1; sw_load_base = 1; pix_valid = 1; step("R10 frame wins");
    pix_valid = 0; step("R10 frame wins");

    // R7: skip alternate frames
    skip_alt_frames = 1;
    sw_fsync = 1; step("R7 frame"); pix_valid = 1; step("R7 kept or dropped");
    sw_fsync = 1; step("R7 frame"); step("R7 next"); step("R7 next"); pix_valid = 0;
    skip_alt_frames = 0;

    // R8: active-low frame sync
    fsync_pol = 0; fsync_raw = 1; step("R8 pol switch"); step("R8 pol idle");
    fsync_raw = 0; step("R8 low edge"); fsync_raw = 1; step("R8 low event"); step("R8 low applied");

    // R13: wrap at top of space
    base0 = 22'h3FFFF9; sw_fsync = 1; step("R13 frame"); step("R13 frame");
    run_words("R13 wrap", 3);
    expect_addr("R13 wrapped", 22'h000004);

    // R11/R12: status and interrupt
    eof_irq_en = 1; step("R12 eof irq");
    eof_clr = 1; step("R11 clear"); step("R11 cleared");
    eol_irq_en = 1; sw_lsync = 1; eol_clr = 1; step("R11 set wins"); step("R12 eol irq");
    eol_clr = 1; step("R11 eol clear"); step("R12 irq low");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      pix_valid = ($urandom % 4) != 0;
      wr_ready  = ($urandom % 5) != 0;
      if ($urandom % 60 == 0) fsync_raw = ~fsync_raw;
      if ($urandom % 15 == 0) lsync_raw = ~lsync_raw;
      sw_fsync     = ($urandom % 150) == 0;
      sw_lsync     = ($urandom % 40) == 0;
      sw_load_base = ($urandom % 200) == 0;
      eof_clr      = ($urandom % 20) == 0;
      eol_clr      = ($urandom % 10) == 0;
      if ($urandom % 100 == 0) begin
        buf_sel = $urandom; skip_alt_frames = $urandom; no_first_stride = $urandom;
        eof_irq_en = $urandom; eol_irq_en = $urandom;
        base0 = $urandom; base1 = $urandom; stride = $urandom % 4096;
      end
      if ($urandom % 500 == 0) lsync_pol = ~lsync_pol;
      step("R3/R5/R10/R11 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule